// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Hub

This block lets any one of up to `NCORES` cores raise an interrupt on another core, and lets the core that receives it find out which cores signalled it and acknowledge each of them. All cores share one command port. A command has a valid strobe, a two-bit operation code, the ID of the issuing core and one ID argument. The argument is the target for a raise or a status query, and the sender for an acknowledge. Query results appear in a shared readback register.

Inside, the block keeps one pending flag for each ordered pair of sender and receiver. A core's interrupt line is the OR of every flag aimed at it. Requests from several senders to the same receiver therefore merge into one asserted level. The receiver issues a source query, which returns a bitmask with bit n set for each core n that has a request pending for it. It then acknowledges the senders one at a time. A core cannot signal itself. Raising a request that is already pending does not stack it.

Top module: `ipi_hub`

## Requirements
- R1: During and after a synchronous active-high reset, `irq_out` and `rdback` are all zero, and no pending flag is set.
- R2: A raise command (`cmd_op` = 0) from core `cmd_src` to core `cmd_arg` sets that pair's pending flag. `irq_out[cmd_arg]` is high from the first clock edge after the command onwards.
- R3: A raise command whose `cmd_arg` equals `cmd_src` is ignored. No interrupt line changes, and a later source query by that core does not show itself.
- R4: A status command (`cmd_op` = 1) loads `rdback` one edge later. Bit 0 is 1 when any request is pending for core `cmd_arg`, and every higher bit is 0.
- R5: A source command (`cmd_op` = 2) loads `rdback` one edge later with a bitmask in which bit n is 1 when core n has a request pending for core `cmd_src`. Several bits may be set at once, for example 1, 2, 4, 8 or 11.
- R6: An acknowledge command (`cmd_op` = 3) clears only the flag from sender `cmd_arg` to receiver `cmd_src`. Flags from other senders remain set, and so does the receiver's interrupt line.
- R7: A core's interrupt line stays high while any flag aimed at it is set. It drops on the edge that clears the last such flag.
- R8: Raising a request that is already pending leaves the state unchanged. One acknowledge clears it, however many times it was raised.
- R9: `rdback` holds its value on every cycle without a valid status or source command.
- R10: When `cmd_valid` is low, the other command inputs have no effect on any flag or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe, one command per cycle |
| cmd_op | input | 2 | Operation: 0 raise, 1 status, 2 source, 3 acknowledge |
| cmd_src | input | ID_W | ID of the issuing core |
| cmd_arg | input | ID_W | Target core (raise, status) or sender core (acknowledge) |
| rdback | output | NCORES | Result of the last query command |
| irq_out | output | NCORES | One registered interrupt level per receiving core |

## Verification
The bench aims at the merge case, where three senders target one core. A design that kept only the latest sender would return 2 or 8 instead of 11. A design that cleared the whole column on an acknowledge would drop the line early. Self-raises are checked because a design that accepted them would light the issuing core's own line. An acknowledge with the sender and receiver swapped would clear the wrong flag and leave the line high. The bench also checks that a repeated raise does not call for two acknowledges, that `rdback` does not move on a raise, an acknowledge or an idle cycle, and that a command without its strobe changes nothing.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    IPI_RAISE  = 2'd0,
    IPI_STATUS = 2'd1,
    IPI_WHO    = 2'd2,
    IPI_ACK    = 2'd3
  } ipi_op_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ID_W   = 2
) (
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [ID_W-1:0] cmd_src,
  input  logic [ID_W-1:0] cmd_arg,
  output logic            raise_en,
  output logic            ack_en,
  output logic            status_en,
  output logic            who_en
);
  ipi_op_e op;
  logic    ids_ok;

  always_comb begin
    op        = ipi_op_e'(cmd_op);
    ids_ok    = (32'(cmd_src) < NCORES) && (32'(cmd_arg) < NCORES);
    // a core may not signal itself: drop the request here
    raise_en  = cmd_valid && ids_ok && (op == IPI_RAISE) && (cmd_src != cmd_arg);
    ack_en    = cmd_valid && ids_ok && (op == IPI_ACK);
    status_en = cmd_valid && ids_ok && (op == IPI_STATUS);
    who_en    = cmd_valid && ids_ok && (op == IPI_WHO);
  end
endmodule

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix #(
  parameter int NCORES = 4,
  parameter int ID_W   = 2,
  localparam int CELLS = NCORES * NCORES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raise_en,
  input  logic             ack_en,
  input  logic [ID_W-1:0]  src,
  input  logic [ID_W-1:0]  arg,
  output logic [CELLS-1:0] pend_q,
  output logic [CELLS-1:0] pend_d
);
  // cell index = sender * NCORES + receiver
  for (genvar s = 0; s < NCORES; s++) begin : g_snd
    for (genvar r = 0; r < NCORES; r++) begin : g_rcv
      logic set_c, clr_c;
      assign set_c = raise_en && (src == ID_W'(s)) && (arg == ID_W'(r));
      assign clr_c = ack_en && (arg == ID_W'(s)) && (src == ID_W'(r));
      assign pend_d[s*NCORES+r] = set_c | (pend_q[s*NCORES+r] & ~clr_c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // R6: after an acknowledge the named pair is clear
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    ack_en |=> !pend_q[int'($past(arg))*NCORES + int'($past(src))]);

  // R8: a raise of an already pending pair changes nothing
  assert_no_stack_R8: assert property (@(posedge clk) disable iff (rst)
    (raise_en && pend_q[int'(src)*NCORES + int'(arg)]) |=> $stable(pend_q));
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
  parameter int NCORES = 4,
  parameter int ID_W   = 2,
  localparam int CELLS = NCORES * NCORES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              status_en,
  input  logic              who_en,
  input  logic [ID_W-1:0]   src,
  input  logic [ID_W-1:0]   arg,
  input  logic [CELLS-1:0]  pend_q,
  output logic [NCORES-1:0] rdback
);
  logic [NCORES-1:0] who_col, stat_col;

  always_comb begin
    for (int s = 0; s < NCORES; s++) begin
      who_col[s]  = pend_q[s*NCORES + int'(src)];
      stat_col[s] = pend_q[s*NCORES + int'(arg)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            rdback <= '0;
    else if (who_en)    rdback <= who_col;
    else if (status_en) rdback <= NCORES'(|stat_col);
  end

  // R9: no query, no change
  assert_rdback_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(status_en || who_en) |=> $stable(rdback));

  // R4: status result uses bit 0 only
  assert_status_fmt_R4: assert property (@(posedge clk) disable iff (rst)
    status_en |=> (rdback >> 1) == '0);
endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ID_W   = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ID_W-1:0]   cmd_src,
  input  logic [ID_W-1:0]   cmd_arg,
  output logic [NCORES-1:0] rdback,
  output logic [NCORES-1:0] irq_out
);
  localparam int CELLS = NCORES * NCORES;

  logic raise_en, ack_en, status_en, who_en;
  logic [CELLS-1:0]  pend_q, pend_d;
  logic [NCORES-1:0] irq_d, irq_now;

  ipi_cmd_decode #(.NCORES(NCORES), .ID_W(ID_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_arg(cmd_arg),
    .raise_en(raise_en), .ack_en(ack_en), .status_en(status_en), .who_en(who_en)
  );

  ipi_pend_matrix #(.NCORES(NCORES), .ID_W(ID_W)) u_mat (
    .clk(clk), .rst(rst), .raise_en(raise_en), .ack_en(ack_en),
    .src(cmd_src), .arg(cmd_arg), .pend_q(pend_q), .pend_d(pend_d)
  );

  ipi_readback #(.NCORES(NCORES), .ID_W(ID_W)) u_rb (
    .clk(clk), .rst(rst), .status_en(status_en), .who_en(who_en),
    .src(cmd_src), .arg(cmd_arg), .pend_q(pend_q), .rdback(rdback)
  );

  // merge all senders per receiver; register from next state so the
  // line tracks the flags on the same edge
  always_comb begin
    irq_d   = '0;
    irq_now = '0;
    for (int r = 0; r < NCORES; r++) begin
      for (int s = 0; s < NCORES; s++) begin
        irq_d[r]   = irq_d[r]   | pend_d[s*NCORES+r];
        irq_now[r] = irq_now[r] | pend_q[s*NCORES+r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= irq_d;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (irq_out == '0) && (rdback == '0));

  assert_raise_line_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'(IPI_RAISE) && cmd_src != cmd_arg
     && 32'(cmd_arg) < NCORES && 32'(cmd_src) < NCORES)
    |=> irq_out[$past(cmd_arg)]);

  assert_no_self_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'(IPI_RAISE) && cmd_src == cmd_arg)
    |=> $stable(irq_out));

  assert_line_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    ##1 irq_out == irq_now);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(irq_out) && $stable(rdback));
endmodule

// File: tb/sim_ipi_hub.sv
module sim_ipi_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [IW-1:0] cmd_src = '0, cmd_arg = '0;
  logic [NC-1:0] rdback, irq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_hub #(.NCORES(NC)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_arg(cmd_arg), .rdback(rdback), .irq_out(irq_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one command, one cycle; on return the edge has taken effect
  task automatic cmd(input int op, input int src, input int arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_src = IW'(src); cmd_arg = IW'(arg);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", int'(irq_out), 0);
    chk("R1 rdback after reset", int'(rdback), 0);
    cmd(2, 1, 0);
    chk("R1 no flags after reset", int'(rdback), 0);
  endtask

  task automatic t_single();
    cmd(0, 0, 2);
    chk("R2 raise 0->2 line", int'(irq_out), 4);
    cmd(1, 3, 2);
    chk("R4 status of core 2", int'(rdback), 1);
    cmd(1, 3, 1);
    chk("R4 status of idle core 1", int'(rdback), 0);
    cmd(2, 2, 0);
    chk("R5 source single sender", int'(rdback), 1);
    cmd(3, 2, 0);
    chk("R7 line drops after ack", int'(irq_out), 0);
  endtask

  task automatic t_self();
    cmd(0, 1, 1);
    chk("R3 self raise line", int'(irq_out), 0);
    cmd(2, 1, 0);
    chk("R3 self raise source", int'(rdback), 0);
  endtask

  task automatic t_merge();
    cmd(0, 0, 2);
    cmd(0, 1, 2);
    cmd(0, 3, 2);
    chk("R5 merged line", int'(irq_out), 4);
    cmd(2, 2, 0);
    chk("R5 merged source mask", int'(rdback), 11);
    cmd(3, 2, 1);
    chk("R6 line held after one ack", int'(irq_out), 4);
    cmd(2, 2, 0);
    chk("R6 only sender 1 cleared", int'(rdback), 9);
    cmd(3, 2, 0);
    cmd(2, 2, 0);
    chk("R6 sender 3 remains", int'(rdback), 8);
    chk("R7 line still high", int'(irq_out), 4);
    cmd(3, 2, 3);
    chk("R7 line drops on last ack", int'(irq_out), 0);
  endtask

  task automatic t_repeat();
    cmd(0, 3, 0);
    cmd(0, 3, 0);
    cmd(2, 0, 0);
    chk("R8 repeated raise mask", int'(rdback), 8);
    cmd(3, 0, 3);
    chk("R8 one ack clears", int'(irq_out), 0);
  endtask

  task automatic t_cross();
    cmd(0, 0, 1);
    cmd(0, 1, 0);
    chk("R2 two receivers", int'(irq_out), 3);
    cmd(3, 0, 0);
    chk("R6 wrong-sender ack keeps line", int'(irq_out), 3);
    cmd(3, 0, 1);
    cmd(3, 1, 0);
    chk("R7 both cleared", int'(irq_out), 0);
  endtask

  task automatic t_hold();
    cmd(0, 0, 1);
    cmd(2, 1, 0);
    chk("R9 source before hold", int'(rdback), 1);
    cmd(0, 2, 3);
    chk("R9 held over raise", int'(rdback), 1);
    cmd(3, 1, 0);
    chk("R9 held over ack", int'(rdback), 1);
    repeat (3) @(negedge clk);
    chk("R9 held while idle", int'(rdback), 1);
    cmd(3, 3, 2);
  endtask

  task automatic t_novalid();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_src = 2'd0; cmd_arg = 2'd3;
    @(negedge clk);
    chk("R10 raise without strobe", int'(irq_out), 0);
    cmd_op = 2'd2; cmd_src = 2'd3;
    @(negedge clk);
    chk("R10 query without strobe", int'(rdback), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_self();
    t_merge();
    t_repeat();
    t_cross();
    t_hold();
    t_novalid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule